// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps the coherence state of cached lines for a small group of write-back caches that share one snooping bus. Every cache keeps, for each line it tracks, one of three states: Invalid (no copy), Shared (a clean copy that may only be read) or Modified (the single valid copy, dirty and writable). Writes gain the right to modify a line by broadcasting a read-for-ownership, which removes every other copy. A dirty owner that observes another cache's read or read-for-ownership hands its data over and writes it back to memory.

One processor request is accepted per clock. It names the requesting cache, the line and an operation: load, store or evict. In the same cycle the block works out the bus command that the request needs from the requester's current state. It also works out how every other cache reacts when it snoops that command, and which cache, if any, must supply dirty data. All line states update at the next rising clock edge. The bus command, its source and the supply and writeback flags are registered and stay visible for one cycle after that edge. A read port returns the states that all caches hold for any chosen line.

Top module: `msi_snoop_cluster`

## Requirements
- R1: While reset is asserted, and right after it is released, every line in every cache reads Invalid (state code 00), the bus command is none (00), and the supply and writeback flags are low. Asserting reset clears the states at once, without waiting for a clock edge.
- R2: A load to an Invalid line issues a bus read (command 01) with the requester's index as the source. The line then becomes Shared (code 01).
- R3: A store to an Invalid or Shared line issues a read-for-ownership (command 10). The line then becomes Modified (code 10).
- R4: A load to a Shared or Modified line, or a store to a Modified line, issues no bus command (00). The line's state does not change.
- R5: When another cache holds the line Modified and observes a bus read, it supplies the data, writes the line back and moves to Shared. The supply flag goes high with that cache's index, and the writeback flag goes high. When no cache supplies data, the supply flag is low and the supply index is 0.
- R6: A read-for-ownership moves every other cache's Shared or Modified copy to Invalid. A Modified holder supplies its data and raises the writeback flag.
- R7: Evicting a Modified line issues a writeback command (11) and leaves the line Invalid. Evicting a Shared line leaves it Invalid with no bus command. Evicting an Invalid line does nothing.
- R8: For every line, at most one cache is Modified, and a Modified copy never coexists with a Shared copy.
- R9: A request with the no-operation code (00), or one that names a cache index not below the number of caches, changes no state and issues no command.
- R10: A request changes only the addressed line. All other lines in all caches keep their states.
- R11: With caches 0, 1 and 2 on one line, the order "0 loads, 2 loads, 2 stores, 0 loads, 1 loads" gives the states (cache 0/1/2) S/I/I, S/I/S, I/I/M, S/I/S and S/S/S. Cache 2 supplies the data on the fourth access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A processor request is present this cycle |
| req_agent | input | AGENT_W | Index of the requesting cache |
| req_line | input | LINE_W | Line addressed by the request |
| req_op | input | 2 | 00 none, 01 load, 10 store, 11 evict |
| look_line | input | LINE_W | Line whose states are shown on look_states |
| look_states | output | 2*AGENTS | State of look_line in every cache, cache g at bits [2g+1:2g] |
| bus_cmd_o | output | 2 | Registered bus command: 00 none, 01 read, 10 read-for-ownership, 11 writeback |
| bus_src_o | output | AGENT_W | Cache that issued bus_cmd_o, 0 when there is no command |
| supply_o | output | 1 | A snooping cache supplies dirty data |
| supply_src_o | output | AGENT_W | Index of the supplying cache, 0 when supply_o is low |
| flush_o | output | 1 | The supplying cache writes its dirty line back to memory |

## Verification
Assertions check the single-writer rule on every line on every cycle. They also check that unaddressed or idle cycles leave the line banks unchanged, that a data supply only follows a read or read-for-ownership, and that loads to Invalid lines and stores to non-Modified lines always produce the matching command. Only the bench's scenarios can show whole transition chains and the states they leave behind. Examples are the five-access sharing sequence, who supplies data after an ownership change, silent eviction of clean lines, rejection of out-of-range requesters, and the immediate clearing on an asynchronous reset.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHD = 2'b01,
    ST_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_WB   = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_EVICT = 2'b11
  } cpu_op_e;

  // Outcome of a snoop for one cache
  typedef struct packed {
    line_st_e nxt;
    logic     supply;
    logic     flush;
  } snoop_res_t;

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/msi_req_decode.sv
// Requester side: the command a processor operation needs and the
// state the requesting line takes afterwards.
module msi_req_decode
  import msi_pkg::*;
(
  input  line_st_e cur,
  input  cpu_op_e  op,
  output line_st_e nxt,
  output bus_cmd_e cmd
);

  always_comb begin
    nxt = cur;
    cmd = CMD_NONE;
    unique case (op)
      OP_LOAD: begin
        if (cur == ST_INV) begin
          nxt = ST_SHD;
          cmd = CMD_RD;
        end
      end
      OP_STORE: begin
        if (cur != ST_MOD) begin
          nxt = ST_MOD;
          cmd = CMD_RDX;
        end
      end
      OP_EVICT: begin
        nxt = ST_INV;
        if (cur == ST_MOD) begin
          cmd = CMD_WB;
        end
      end
      default: begin
        nxt = cur;
        cmd = CMD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/msi_snoop_resp.sv
// Snooper side: reaction of one cache that observes another cache's command.
module msi_snoop_resp
  import msi_pkg::*;
(
  input  line_st_e   cur,
  input  bus_cmd_e   cmd,
  output snoop_res_t res
);

  always_comb begin
    res.nxt    = cur;
    res.supply = 1'b0;
    res.flush  = 1'b0;
    unique case (cmd)
      CMD_RD: begin
        if (cur == ST_MOD) begin
          res.nxt    = ST_SHD;
          res.supply = 1'b1;
          res.flush  = 1'b1;
        end
      end
      CMD_RDX: begin
        if (cur == ST_MOD) begin
          res.supply = 1'b1;
          res.flush  = 1'b1;
        end
        res.nxt = ST_INV;
      end
      default: begin
        res.nxt = cur;
      end
    endcase
  end

endmodule

// File: rtl/msi_line_bank.sv
// State registers for all lines of one cache.
module msi_line_bank
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int LINE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LINE_W-1:0]    wr_line,
  input  line_st_e             wr_state,
  output logic [2*LINES-1:0]   states
);

  logic [2*LINES-1:0] st_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic     en_l;
    line_st_e st_l_q;

    assign en_l = wr_en && (wr_line == LINE_W'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_l_q <= ST_INV;
      end else if (en_l) begin
        st_l_q <= wr_state;
      end
    end

    assign st_q[2*l +: 2] = st_l_q;
  end

  assign states = st_q;

  // R10: without a write every line keeps its state
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st_q));

endmodule

// File: rtl/msi_snoop_cluster.sv
module msi_snoop_cluster
  import msi_pkg::*;
#(
  parameter int AGENTS  = 3,
  parameter int LINES   = 4,
  parameter int AGENT_W = 2,
  parameter int LINE_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [AGENT_W-1:0]    req_agent,
  input  logic [LINE_W-1:0]     req_line,
  input  logic [1:0]            req_op,
  input  logic [LINE_W-1:0]     look_line,
  output logic [2*AGENTS-1:0]   look_states,
  output logic [1:0]            bus_cmd_o,
  output logic [AGENT_W-1:0]    bus_src_o,
  output logic                  supply_o,
  output logic [AGENT_W-1:0]    supply_src_o,
  output logic                  flush_o
);

  localparam int BANK_W = 2 * LINES;

  logic rst_s_n;

  msi_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // ---------------- request qualification ----------------
  logic               agent_ok;
  logic               req_hit;
  logic [AGENT_W-1:0] agent_idx;
  cpu_op_e            op_c;

  assign op_c      = cpu_op_e'(req_op);
  assign agent_ok  = (int'(req_agent) < AGENTS);
  assign req_hit   = req_valid && agent_ok && (op_c != OP_NOP);
  assign agent_idx = agent_ok ? req_agent : '0;

  // ---------------- state banks ----------------
  logic [BANK_W-1:0] bank_q  [AGENTS];
  line_st_e          cur_a   [AGENTS];
  line_st_e          wr_st_a [AGENTS];
  snoop_res_t        snp_a   [AGENTS];
  logic [AGENTS-1:0] supply_vec;
  logic [AGENTS-1:0] flush_vec;

  line_st_e req_cur;
  line_st_e req_nxt;
  bus_cmd_e cmd_c;

  assign req_cur = cur_a[agent_idx];

  msi_req_decode i_req_decode (
    .cur (req_cur),
    .op  (op_c),
    .nxt (req_nxt),
    .cmd (cmd_c)
  );

  for (genvar g = 0; g < AGENTS; g++) begin : g_agent
    logic     is_req;
    bus_cmd_e seen_cmd;

    assign is_req   = req_hit && (agent_idx == AGENT_W'(g));
    assign seen_cmd = (req_hit && !is_req) ? cmd_c : CMD_NONE;
    assign cur_a[g] = line_st_e'(bank_q[g][2*req_line +: 2]);

    msi_snoop_resp i_snoop (
      .cur (cur_a[g]),
      .cmd (seen_cmd),
      .res (snp_a[g])
    );

    assign wr_st_a[g]    = is_req ? req_nxt : snp_a[g].nxt;
    assign supply_vec[g] = snp_a[g].supply;
    assign flush_vec[g]  = snp_a[g].flush;

    msi_line_bank #(
      .LINES  (LINES),
      .LINE_W (LINE_W)
    ) i_bank (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_en    (req_hit),
      .wr_line  (req_line),
      .wr_state (wr_st_a[g]),
      .states   (bank_q[g])
    );

    assign look_states[2*g +: 2] = bank_q[g][2*look_line +: 2];
  end

  // ---------------- output next-state ----------------
  logic [AGENT_W-1:0] supply_src_c;
  logic               supply_c;
  logic               flush_c;
  bus_cmd_e           cmd_d;
  logic [AGENT_W-1:0] src_d;

  always_comb begin
    supply_src_c = '0;
    for (int g = 0; g < AGENTS; g++) begin
      if (supply_vec[g]) begin
        supply_src_c = AGENT_W'(g);
      end
    end
  end

  assign supply_c = |supply_vec;
  assign flush_c  = |flush_vec;
  assign cmd_d    = req_hit ? cmd_c : CMD_NONE;
  assign src_d    = (cmd_d != CMD_NONE) ? agent_idx : '0;

  // ---------------- output registers ----------------
  bus_cmd_e           cmd_q;
  logic [AGENT_W-1:0] src_q;
  logic               supply_q;
  logic [AGENT_W-1:0] supply_src_q;
  logic               flush_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd_q        <= CMD_NONE;
      src_q        <= '0;
      supply_q     <= 1'b0;
      supply_src_q <= '0;
      flush_q      <= 1'b0;
    end else begin
      cmd_q        <= cmd_d;
      src_q        <= src_d;
      supply_q     <= supply_c;
      supply_src_q <= supply_src_c;
      flush_q      <= flush_c;
    end
  end

  assign bus_cmd_o    = cmd_q;
  assign bus_src_o    = src_q;
  assign supply_o     = supply_q;
  assign supply_src_o = supply_src_q;
  assign flush_o      = flush_q;

  // ---------------- assertions ----------------
  for (genvar l = 0; l < LINES; l++) begin : g_inv
    logic [AGENTS-1:0] mod_v;
    logic [AGENTS-1:0] shd_v;
    for (genvar g = 0; g < AGENTS; g++) begin : g_bits
      assign mod_v[g] = (bank_q[g][2*l +: 2] == ST_MOD);
      assign shd_v[g] = (bank_q[g][2*l +: 2] == ST_SHD);
    end

    // R8: a single writer per line
    p_one_writer_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
      $onehot0(mod_v));

    // R8: a dirty copy excludes clean sharers
    p_mod_excl_shd_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
      (|mod_v) |-> (shd_v == '0));
  end

  // R9: idle cycles leave the bus quiet
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_hit |=> (bus_cmd_o == CMD_NONE) && !supply_o && !flush_o);

  // R5: data is only supplied in answer to a read or a read-for-ownership
  p_supply_on_read_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    supply_o |-> (bus_cmd_o == CMD_RD) || (bus_cmd_o == CMD_RDX));

  // R2: a load that misses is seen on the bus as a read
  p_load_miss_rd_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_hit && op_c == OP_LOAD && req_cur == ST_INV) |=> (bus_cmd_o == CMD_RD));

  // R3: a store without ownership is seen as a read-for-ownership
  p_store_rdx_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_hit && op_c == OP_STORE && req_cur != ST_MOD) |=> (bus_cmd_o == CMD_RDX));

endmodule

// File: tb/test_msi_snoop_cluster.sv
module test_msi_snoop_cluster;

  localparam int AGENTS  = 3;
  localparam int LINES   = 4;
  localparam int AGENT_W = 2;
  localparam int LINE_W  = 2;

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic [AGENT_W-1:0]  req_agent;
  logic [LINE_W-1:0]   req_line;
  logic [1:0]          req_op;
  logic [LINE_W-1:0]   look_line;
  logic [2*AGENTS-1:0] look_states;
  logic [1:0]          bus_cmd_o;
  logic [AGENT_W-1:0]  bus_src_o;
  logic                supply_o;
  logic [AGENT_W-1:0]  supply_src_o;
  logic                flush_o;

  int checks;
  int errors;

  msi_snoop_cluster #(
    .AGENTS  (AGENTS),
    .LINES   (LINES),
    .AGENT_W (AGENT_W),
    .LINE_W  (LINE_W)
  ) i_msi_snoop_cluster (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_agent    (req_agent),
    .req_line     (req_line),
    .req_op       (req_op),
    .look_line    (look_line),
    .look_states  (look_states),
    .bus_cmd_o    (bus_cmd_o),
    .bus_src_o    (bus_src_o),
    .supply_o     (supply_o),
    .supply_src_o (supply_src_o),
    .flush_o      (flush_o)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] ag, input logic [1:0] ln, input logic [1:0] op);
    req_valid = 1'b1;
    req_agent = ag;
    req_line  = ln;
    req_op    = op;
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 2'b00;
  endtask

  // {agent[15:14], op[13:12], cmd[11:10], supply[9], supply_src[8:7],
  //  flush[6], states line 0 {c2,c1,c0}[5:0]}; I=00 S=01 M=10
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 6'b00_00_01}, // R2 R11 step 1
    {2'd2, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 6'b01_00_01}, // R2 R11 step 2
    {2'd2, 2'd2, 2'd2, 1'b0, 2'd0, 1'b0, 6'b10_00_00}, // R3 R6 R11 step 3
    {2'd0, 2'd1, 2'd1, 1'b1, 2'd2, 1'b1, 6'b01_00_01}, // R5 R11 step 4
    {2'd1, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 6'b01_01_01}, // R2 R11 step 5
    {2'd1, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 6'b01_01_01}, // R4 load on S
    {2'd1, 2'd2, 2'd2, 1'b0, 2'd0, 1'b0, 6'b00_10_00}, // R3 store on S, R6 sharers drop
    {2'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 6'b00_10_00}, // R4 store on M
    {2'd1, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 6'b00_10_00}, // R4 load on M
    {2'd0, 2'd2, 2'd2, 1'b1, 2'd1, 1'b1, 6'b00_00_10}, // R6 dirty owner supplies
    {2'd0, 2'd3, 2'd3, 1'b0, 2'd0, 1'b0, 6'b00_00_00}, // R7 evict M
    {2'd0, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 6'b00_00_00}, // R7 evict I
    {2'd2, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 6'b01_00_00}, // R2 load miss
    {2'd2, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 6'b00_00_00}, // R7 silent evict S
    {2'd3, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 6'b00_00_00}, // R9 agent out of range
    {2'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 6'b00_00_00}  // R9 no-operation code
  };

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_agent = '0;
    req_line  = '0;
    req_op    = 2'b00;
    look_line = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 states in reset", 8'(look_states), 8'h00);
    chk("R1 cmd in reset", 8'(bus_cmd_o), 8'h00);
    chk("R1 supply in reset", 8'(supply_o), 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 states after release", 8'(look_states), 8'h00);
    chk("R1 flush after release", 8'(flush_o), 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      int nmod;
      v = VEC[i];
      issue(v[15:14], 2'd0, v[13:12]);
      chk($sformatf("R2-R9 R11 step %0d bus cmd", i), 8'(bus_cmd_o), 8'(v[11:10]));
      if (v[11:10] != 2'b00)
        chk($sformatf("R2 step %0d bus source", i), 8'(bus_src_o), 8'(v[15:14]));
      chk($sformatf("R5 R6 step %0d supply", i), 8'(supply_o), 8'(v[9]));
      chk($sformatf("R5 R6 step %0d supply source", i), 8'(supply_src_o), 8'(v[8:7]));
      chk($sformatf("R5 R6 step %0d flush", i), 8'(flush_o), 8'(v[6]));
      chk($sformatf("R11 step %0d states", i), 8'(look_states), 8'(v[5:0]));
      nmod = 0;
      for (int g = 0; g < AGENTS; g++) if (look_states[2*g +: 2] == 2'b10) nmod++;
      chk($sformatf("R8 step %0d writers", i), 8'(nmod > 1), 8'h00);
    end

    // R10: another line is untouched
    issue(2'd1, 2'd2, 2'd2);
    chk("R10 cmd on line 2", 8'(bus_cmd_o), 8'h02);
    chk("R10 line 0 unchanged", 8'(look_states), 8'h00);
    issue(2'd0, 2'd0, 2'd1);
    look_line = 2'd2;
    #1;
    chk("R10 line 2 owner kept", 8'(look_states), 8'b00_10_00);
    look_line = 2'd3;
    #1;
    chk("R10 line 3 untouched", 8'(look_states), 8'h00);
    look_line = 2'd0;
    #1;
    chk("R10 line 0 load landed", 8'(look_states), 8'b00_00_01);

    // R1: asynchronous reset clears at once
    issue(2'd2, 2'd0, 2'd2);
    chk("R1 pre-reset owner", 8'(look_states), 8'b10_00_00);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear states", 8'(look_states), 8'h00);
    chk("R1 async clear cmd", 8'(bus_cmd_o), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 after reset: eviction of an untouched line is silent
    issue(2'd1, 2'd3, 2'd3);
    chk("R7 evict fresh line", 8'(bus_cmd_o), 8'h00);

    summary();
  end

endmodule